// File: doc/BRIEF.md
# Multi-Unit Timestamp Synchronization Controller

This block lines up the timestamp counters of several units that share one timestamp clock. Software writes a control word to arm the circuit. While armed, the block holds the counters and scalers in reset with the time value at zero. A later sync event releases the hold on one timestamp clock edge. Every unit in the chain sees the same sync edge, so all counters start together.

A sync event comes from one of two sources. Software can write a command bit, or a group of 64 input lines can be used. These lines are filtered by a 64-bit selection mask and then ORed together. Only a rising edge of the combined source counts, so a line held high gives one event. The block re-times each event to the timestamp clock and drives it out as a one-cycle pulse, which the next unit down the chain can use as its input. Command pulses cross from the bus clock into the timestamp clock. The armed, done and received flags are reported twice in one status word: once as tracked in the bus domain, and once as carried back from the timestamp domain.

The register port has three addresses. Address 0 is control on write and status on read. Address 1 holds mask lines 31..0 and address 2 holds lines 63..32.

Top module: `ts_sync_ctrl`

## Requirements
- R1: A write to address 0 with bit 31 set (bit 30 clear) arms the circuit. Status bit 15 is set on the next bus cycle. Once the timestamp domain has taken the command, the status word equals 0x8800 and `ts_cnt_rst` is high.
- R2: A sync event while armed clears `ts_cnt_rst` on the same timestamp edge on which `sync_out` rises. Once the flags have crossed back, the status word equals 0x6600: done (14, 10) and received (13, 9) are set, armed (15, 11) is clear.
- R3: Every rising edge of the combined sync source gives exactly one `sync_out` pulse one timestamp cycle long, whether or not the circuit is armed.
- R4: A write to address 0 with bit 30 set disarms the circuit. It clears status bits 15..13 on the next bus cycle. It brings the status word to 0 and drops `ts_cnt_rst`.
- R5: Arming clears the done and received flags left by an earlier sync, so the status word returns to 0x8800.
- R6: A sync event while not armed leaves the status word and `ts_cnt_rst` unchanged.
- R7: Input line k takes part in the sync source only when mask bit k is set. A rising edge on a line whose mask bit is clear causes no sync.
- R8: With the whole mask at zero, no input line can cause a sync. Only the software trigger is left: a write to address 0 with bit 16 set.
- R9: Mask bit k is held in word k/32 + 1, at bit k mod 32. It reads back at that address. Reading an address above 2 returns 0.
- R10: A read of address 0 returns the status word. Bits 12, 8 and 7..0 of the status word are always zero.
- R11: After reset the status word is 0, `ts_cnt_rst` is low and `sync_out` is low.
- R12: When bits 31 and 30 are written together, disarm takes precedence. The status word becomes 0 and `ts_cnt_rst` stays low.
- R13: An input line held high across many timestamp cycles produces only one sync event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register bus clock |
| rst_bus_n | input | 1 | Active-low reset, bus domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1..2 mask words |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address: 0 status, 1..2 mask words |
| rd_data | output | 32 | Read data for `rd_addr` |
| status | output | 32 | Status word (bus domain) |
| ext_in | input | 64 | Asynchronous sync input lines |
| clk_ts | input | 1 | Timestamp clock |
| rst_ts_n | input | 1 | Active-low reset, timestamp domain |
| ts_cnt_rst | output | 1 | Hold for timestamp counters and scalers |
| sync_out | output | 1 | Re-timed sync pulse for the next unit |

## Verification
Every one of the 64 input lines is tried on its own, with the mask selecting only that line. Before the selected line is raised, its neighbour is raised first. This separates a correct mask decode from one that is stuck, shifted or placed in the wrong word. An all-ones input pattern with a zero mask shows that only the software trigger can fire. A line held high for many cycles separates edge detection from level detection. The software trigger is applied in three states: armed, already synced and disarmed. This separates the arm gating from the pulse forwarding, which happens in every state.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;
   // control command bits (address 0 write)
   localparam int CMD_ARM    = 31;
   localparam int CMD_DISARM = 30;
   localparam int CMD_SYNC   = 16;
   // status bits (address 0 read)
   localparam int ST_ARM_B   = 15;
   localparam int ST_DONE_B  = 14;
   localparam int ST_RCVD_B  = 13;
   localparam int ST_ARM_T   = 11;
   localparam int ST_DONE_T  = 10;
   localparam int ST_RCVD_T  = 9;

   typedef struct packed {
      logic armed;
      logic done;
      logic rcvd;
   } sync_flags_t;
endpackage

// File: rtl/tss_sync_stages.sv
module tss_sync_stages #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tss_sync_stages: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tss_bus_regs.sv
module tss_bus_regs
   import ts_sync_pkg::*;
#(
   parameter int DW        = 32,
   parameter int NUM_WORDS = 2,
   parameter int AW        = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  logic [DW-1:0]           wr_data,
   input  logic [AW-1:0]           rd_addr,
   input  sync_flags_t             flags_ts,
   output logic                    arm_tgl,
   output logic                    disarm_tgl,
   output logic                    swsync_tgl,
   output logic [NUM_WORDS*DW-1:0] mask_all,
   output logic [DW-1:0]           status,
   output logic [DW-1:0]           rd_data
);
   logic [DW-1:0] mask_w [NUM_WORDS];
   sync_flags_t   flags_q;
   logic          armed_b, done_b, rcvd_b;
   logic          ctl_wr, done_rise, rcvd_rise;

   assign ctl_wr    = wr_en && (wr_addr == '0);
   assign done_rise = flags_ts.done & ~flags_q.done;
   assign rcvd_rise = flags_ts.rcvd & ~flags_q.rcvd;

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mask
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mask_w[w] <= '0;
            else if (wr_en && wr_addr == AW'(w + 1))
               mask_w[w] <= wr_data;
         end
         assign mask_all[w*DW +: DW] = mask_w[w];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q    <= '0;
         armed_b    <= 1'b0;
         done_b     <= 1'b0;
         rcvd_b     <= 1'b0;
         arm_tgl    <= 1'b0;
         disarm_tgl <= 1'b0;
         swsync_tgl <= 1'b0;
      end else begin
         flags_q <= flags_ts;
         if (ctl_wr && wr_data[CMD_DISARM]) begin
            disarm_tgl <= ~disarm_tgl;
            armed_b    <= 1'b0;
            done_b     <= 1'b0;
            rcvd_b     <= 1'b0;
         end else if (ctl_wr && wr_data[CMD_ARM]) begin
            arm_tgl <= ~arm_tgl;
            armed_b <= 1'b1;
            done_b  <= 1'b0;
            rcvd_b  <= 1'b0;
         end else begin
            if (done_rise) begin
               armed_b <= 1'b0;
               done_b  <= 1'b1;
            end
            if (rcvd_rise) rcvd_b <= 1'b1;
         end
         if (ctl_wr && wr_data[CMD_SYNC]) swsync_tgl <= ~swsync_tgl;
      end
   end

   always_comb begin
      status            = '0;
      status[ST_ARM_B]  = armed_b;
      status[ST_DONE_B] = done_b;
      status[ST_RCVD_B] = rcvd_b;
      status[ST_ARM_T]  = flags_ts.armed;
      status[ST_DONE_T] = flags_ts.done;
      status[ST_RCVD_T] = flags_ts.rcvd;
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == '0) rd_data = status;
      for (int w = 0; w < NUM_WORDS; w++)
         if (rd_addr == AW'(w + 1)) rd_data = mask_w[w];
   end
endmodule

// File: rtl/tss_ts_core.sv
module tss_ts_core
   import ts_sync_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        arm_tgl,
   input  logic        disarm_tgl,
   input  logic        swsync_tgl,
   input  logic        ext_hit,
   output sync_flags_t flags,
   output logic        cnt_rst,
   output logic        sync_out
);
   logic [3:0] in_s;
   logic [2:0] tgl_q;
   logic       arm_p, disarm_p, sw_p, sync_lvl, sync_q, sync_rise;

   tss_sync_stages #(.W(4), .STAGES(STAGES)) u_in_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({arm_tgl, disarm_tgl, swsync_tgl, ext_hit}),
      .q     (in_s)
   );

   assign arm_p     = in_s[3] ^ tgl_q[2];
   assign disarm_p  = in_s[2] ^ tgl_q[1];
   assign sw_p      = in_s[1] ^ tgl_q[0];
   assign sync_lvl  = in_s[0] | sw_p;
   assign sync_rise = sync_lvl & ~sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgl_q    <= '0;
         sync_q   <= 1'b0;
         sync_out <= 1'b0;
         flags    <= '0;
      end else begin
         tgl_q    <= in_s[3:1];
         sync_q   <= sync_lvl;
         sync_out <= sync_rise;
         if (disarm_p) begin
            flags <= '0;
         end else if (sync_rise && flags.armed) begin
            flags.armed <= 1'b0;
            flags.done  <= 1'b1;
            flags.rcvd  <= 1'b1;
         end else if (arm_p) begin
            flags.armed <= 1'b1;
            flags.done  <= 1'b0;
            flags.rcvd  <= 1'b0;
         end
      end
   end

   assign cnt_rst = flags.armed;
endmodule

// File: rtl/ts_sync_ctrl.sv
module ts_sync_ctrl
   import ts_sync_pkg::*;
#(
   parameter  int NUM_LINES   = 64,
   parameter  int DW          = 32,
   parameter  int SYNC_STAGES = 2,
   localparam int NUM_WORDS   = (NUM_LINES + DW - 1) / DW,
   localparam int AW          = $clog2(NUM_WORDS + 1)
) (
   input  logic                 clk_bus,
   input  logic                 rst_bus_n,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic [DW-1:0]        wr_data,
   input  logic [AW-1:0]        rd_addr,
   output logic [DW-1:0]        rd_data,
   output logic [DW-1:0]        status,
   input  logic [NUM_LINES-1:0] ext_in,
   input  logic                 clk_ts,
   input  logic                 rst_ts_n,
   output logic                 ts_cnt_rst,
   output logic                 sync_out
);
   generate
      if (DW < 32) begin : g_bad_dw
         $error("ts_sync_ctrl: DW must be at least 32");
      end
      if (NUM_LINES < 1) begin : g_bad_lines
         $error("ts_sync_ctrl: NUM_LINES must be positive");
      end
   endgenerate

   logic [NUM_WORDS*DW-1:0] mask_all;
   logic                    arm_tgl, disarm_tgl, swsync_tgl, ext_hit;
   sync_flags_t             flags_ts, flags_bus;
   logic [2:0]              flags_bus_raw;

   tss_bus_regs #(.DW(DW), .NUM_WORDS(NUM_WORDS), .AW(AW)) u_regs (
      .clk        (clk_bus),
      .rst_n      (rst_bus_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .flags_ts   (flags_bus),
      .arm_tgl    (arm_tgl),
      .disarm_tgl (disarm_tgl),
      .swsync_tgl (swsync_tgl),
      .mask_all   (mask_all),
      .status     (status),
      .rd_data    (rd_data)
   );

   // one masked-OR bit crosses the domain instead of every line
   assign ext_hit = |(ext_in & mask_all[NUM_LINES-1:0]);

   tss_ts_core #(.STAGES(SYNC_STAGES)) u_core (
      .clk        (clk_ts),
      .rst_n      (rst_ts_n),
      .arm_tgl    (arm_tgl),
      .disarm_tgl (disarm_tgl),
      .swsync_tgl (swsync_tgl),
      .ext_hit    (ext_hit),
      .flags      (flags_ts),
      .cnt_rst    (ts_cnt_rst),
      .sync_out   (sync_out)
   );

   tss_sync_stages #(.W(3), .STAGES(SYNC_STAGES)) u_flag_sync (
      .clk   (clk_bus),
      .rst_n (rst_bus_n),
      .d     (flags_ts),
      .q     (flags_bus_raw)
   );
   assign flags_bus = sync_flags_t'(flags_bus_raw);
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
   parameter int DW = 32,
   parameter int AW = 2
) (
   input logic          clk_bus,
   input logic          rst_bus_n,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic [DW-1:0] status,
   input logic          clk_ts,
   input logic          rst_ts_n,
   input logic          ts_cnt_rst,
   input logic          sync_out
);
   assert_arm_sets_armed_R1: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      (wr_en && wr_addr == '0 && wr_data[31] && !wr_data[30])
      |=> (status[15] && !status[14] && !status[13]));

   assert_disarm_clears_R4: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      (wr_en && wr_addr == '0 && wr_data[30]) |=> (status[15:13] == 3'b000));

   assert_done_not_armed_R2: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      !(status[15] && status[14]));

   assert_done_implies_rcvd_R5: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      status[14] |-> status[13]);

   assert_sync_single_cycle_R3: assert property (@(posedge clk_ts) disable iff (!rst_ts_n)
      sync_out |=> !sync_out);

   assert_release_on_sync_R2: assert property (@(posedge clk_ts) disable iff (!rst_ts_n)
      (sync_out && $past(ts_cnt_rst)) |-> !ts_cnt_rst);
endmodule

bind ts_sync_ctrl tss_checker #(.DW(DW), .AW(AW)) u_chk (
   .clk_bus    (clk_bus),
   .rst_bus_n  (rst_bus_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .status     (status),
   .clk_ts     (clk_ts),
   .rst_ts_n   (rst_ts_n),
   .ts_cnt_rst (ts_cnt_rst),
   .sync_out   (sync_out)
);

// File: tb/ts_sync_ctrl_tb.sv
module ts_sync_ctrl_tb;
   logic        clk_bus = 1'b0, clk_ts = 1'b0;
   logic        rst_bus_n = 1'b0, rst_ts_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data, status;
   logic [63:0] ext_in = '0;
   logic        ts_cnt_rst, sync_out;

   int n_checks = 0, n_fails = 0, sync_cnt = 0;
   bit finished = 1'b0;

   always #4  clk_bus = ~clk_bus;
   always #40 clk_ts  = ~clk_ts;

   ts_sync_ctrl u_dut (
      .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .status(status),
      .ext_in(ext_in), .clk_ts(clk_ts), .rst_ts_n(rst_ts_n),
      .ts_cnt_rst(ts_cnt_rst), .sync_out(sync_out)
   );

   always @(negedge clk_ts) if (sync_out) sync_cnt++;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_ts(input int n);
      repeat (n) @(posedge clk_ts);
      @(negedge clk_bus);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk_bus);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk_bus);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse_line(input int k, input int hold);
      @(negedge clk_bus);
      ext_in = 64'd1 << k;
      wait_ts(hold);
      ext_in = '0;
      wait_ts(8);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
   endtask

   initial begin
      #1200000;
      if (!finished) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         summary();
         $finish;
      end
   end

   initial begin
      int base;
      repeat (10) @(negedge clk_bus);
      rst_bus_n = 1'b1; rst_ts_n = 1'b1;
      wait_ts(3);

      // R11 reset state
      chk(status == 0, "R11 status", status, 0);
      chk(ts_cnt_rst == 0 && sync_cnt == 0, "R11 outputs", {ts_cnt_rst, sync_cnt[7:0]}, 0);

      // R9 mask readback and layout
      wr(2'd1, 32'hA5A5_0001);
      wr(2'd2, 32'h0000_0010);
      rd_addr = 2'd1; #1;
      chk(rd_data == 32'hA5A5_0001, "R9 word1", rd_data, 32'hA5A5_0001);
      rd_addr = 2'd2; #1;
      chk(rd_data == 32'h0000_0010, "R9 word2", rd_data, 32'h10);
      rd_addr = 2'd3; #1;
      chk(rd_data == 0, "R9 unused addr", rd_data, 0);
      // R10 status read
      rd_addr = 2'd0; #1;
      chk(rd_data == status, "R10 status read", rd_data, status);
      wr(2'd1, 0);
      wr(2'd2, 0);

      // R1 arm
      wr(2'd0, 32'h8000_0000);
      chk(status[15] == 1'b1, "R1 immediate armed", status, 32'h8000);
      wait_ts(8);
      chk(status == 32'h8800, "R1 armed status", status, 32'h8800);
      chk(ts_cnt_rst == 1, "R1 counter hold", ts_cnt_rst, 1);

      // R8 zero mask, all lines high
      base = sync_cnt;
      @(negedge clk_bus); ext_in = '1;
      wait_ts(4); ext_in = '0; wait_ts(8);
      chk(status == 32'h8800, "R8 no sync from lines", status, 32'h8800);
      chk(sync_cnt == base, "R8 no pulse", sync_cnt, base);

      // R2 software sync while armed
      wr(2'd0, 32'h0001_0000);
      wait_ts(8);
      chk(status == 32'h6600, "R2 done status", status, 32'h6600);
      chk(ts_cnt_rst == 0, "R2 release", ts_cnt_rst, 0);
      chk(sync_cnt == base + 1, "R3 one pulse", sync_cnt, base + 1);

      // R6 sync after done: ignored, still forwarded
      wr(2'd0, 32'h0001_0000);
      wait_ts(8);
      chk(status == 32'h6600, "R6 done unchanged", status, 32'h6600);
      chk(sync_cnt == base + 2, "R3 forwarded", sync_cnt, base + 2);

      // R5 re-arm clears done and received
      wr(2'd0, 32'h8000_0000);
      wait_ts(8);
      chk(status == 32'h8800, "R5 rearm status", status, 32'h8800);

      // R4 disarm
      wr(2'd0, 32'h4000_0000);
      chk(status[15:13] == 0, "R4 immediate clear", status, 0);
      wait_ts(8);
      chk(status == 0 && ts_cnt_rst == 0, "R4 disarmed", {ts_cnt_rst, status}, 0);

      // R6 sync while disarmed
      wr(2'd0, 32'h0001_0000);
      wait_ts(8);
      chk(status == 0 && ts_cnt_rst == 0, "R6 unarmed ignored", {ts_cnt_rst, status}, 0);

      // R12 arm and disarm together
      wr(2'd0, 32'hC000_0000);
      wait_ts(8);
      chk(status == 0 && ts_cnt_rst == 0, "R12 disarm wins", {ts_cnt_rst, status}, 0);

      // R13 held line counts once (line 36 = word 2 bit 4)
      wr(2'd2, 32'h0000_0010);
      wr(2'd0, 32'h8000_0000);
      wait_ts(8);
      base = sync_cnt;
      pulse_line(36, 20);
      chk(sync_cnt == base + 1, "R13 single event", sync_cnt, base + 1);
      chk(status == 32'h6600, "R13 done", status, 32'h6600);
      wr(2'd2, 0);

      // R7 sweep over every line
      for (int i = 0; i < 64; i++) begin
         int j;
         j = (i + 1) % 64;
         wr(2'd1, (i < 32) ? (32'd1 << i) : 32'd0);
         wr(2'd2, (i >= 32) ? (32'd1 << (i - 32)) : 32'd0);
         wr(2'd0, 32'h8000_0000);
         wait_ts(8);
         base = sync_cnt;
         pulse_line(j, 3);
         chk(status == 32'h8800 && sync_cnt == base, $sformatf("R7 unselected line %0d", j),
             {sync_cnt[15:0], status}, {base[15:0], 32'h8800});
         pulse_line(i, 3);
         chk(status == 32'h6600 && sync_cnt == base + 1, $sformatf("R7 selected line %0d", i),
             {sync_cnt[15:0], status}, {16'(base + 1), 32'h6600});
      end

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule